// File: doc/BRIEF.md
# Bit Test, Clear, Set and Shift Execution Unit

This unit carries out the bit-page operations of an 8-bit legacy processor. It takes the operation byte that follows the bit-page prefix, one 8-bit operand and the current flag byte. One cycle later it returns a result byte, a write-back enable, the register code to write, the new flag byte and a flag that marks an undefined operation. The register file and any memory operand fetch stay outside: the operand arrives already read, and the caller uses the returned register code and write enable to store the result.

The operation byte is split into three fields. The top two bits pick the group: shift/rotate, bit test, bit clear or bit set. The middle three bits give either a bit number or a shift/rotate sub-operation. The low three bits give the register code. Register codes are B=0, C=1, D=2, E=3, H=4, L=5, memory-through-HL=6 and A=7; the unit passes this code through unchanged. One new operation can be accepted on every clock.

Top module: `bsr_unit`

## Requirements
- R1: While reset is asserted, and until the first accepted operation has been returned, `out_vld`, `out_wr` and `out_illegal` are 0.
- R2: An operation accepted with `in_vld` high is presented on the outputs exactly one clock later with `out_vld` high, and `out_dst` equals bits 2:0 of the operation byte.
- R3: Operation bytes 0x40 to 0x7F (bits 7:6 = 01) test the bit numbered by bits 5:3. The zero flag (flag bit 6) becomes the inverse of that operand bit, the other seven flag bits are unchanged, `out_wr` is 0 and `out_res` equals the operand.
- R4: Operation bytes 0x80 to 0xBF (bits 7:6 = 10) clear the bit numbered by bits 5:3 in the operand. `out_wr` is 1 and the flag byte is unchanged.
- R5: Operation bytes 0xC0 to 0xFF (bits 7:6 = 11) set the bit numbered by bits 5:3 in the operand. `out_wr` is 1 and the flag byte is unchanged.
- R6: In the 0x00 to 0x3F range, sub-operation 0 (bits 5:3) rotates left circularly and sub-operation 1 rotates right circularly. The bit that wraps around is also copied to carry.
- R7: Sub-operation 2 rotates left through carry and sub-operation 3 rotates right through carry. The incoming carry (flag bit 0) enters the vacated end.
- R8: Sub-operation 4 shifts left and fills bit 0 with 0. Sub-operation 5 shifts right and keeps bit 7. Sub-operation 7 shifts right and fills bit 7 with 0.
- R9: For sub-operations 0 to 5 and 7, carry (flag bit 0) receives the bit shifted out, zero (flag bit 6) is set exactly when the result is 0, and sign (flag bit 7) equals result bit 7. Flag bits 5:1 are unchanged and `out_wr` is 1.
- R10: Sub-operation 6 is undefined. `out_illegal` is 1, `out_res` equals the operand, `out_wr` is 0 and the flag byte is unchanged. `out_illegal` is 0 for every other operation byte.
- R11: `out_vld` is high only in the cycle after a cycle in which `in_vld` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a synchroniser |
| in_vld | input | 1 | Operation valid this cycle |
| in_op | input | 8 | Operation byte following the bit-page prefix |
| in_opnd | input | 8 | Operand value |
| in_flags | input | 8 | Incoming flag byte (bit 0 carry, bit 6 zero, bit 7 sign) |
| out_vld | output | 1 | Result valid |
| out_res | output | 8 | Result byte |
| out_wr | output | 1 | Write-back enable for `out_res` |
| out_dst | output | 3 | Register code to write |
| out_flags | output | 8 | Updated flag byte |
| out_illegal | output | 1 | Undefined operation marker |

## Verification
The assertions take it that the operation byte, operand and flags are stable and known in every cycle where `in_vld` is high, and that nothing about them matters while it is low. They relate each output to the inputs sampled one cycle earlier, so a valid cycle must be fed with fully driven values. The stimulus keeps to this by driving all inputs together on the falling edge, with `in_vld` raised only while they hold a defined operation, and by sweeping all 256 operation bytes against several operand and carry patterns both back to back and with idle cycles in between.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  localparam int OP_W   = 8;
  localparam int FLAG_W = 8;
  localparam int FLG_C  = 0;
  localparam int FLG_Z  = 6;
  localparam int FLG_S  = 7;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'b00,
    GRP_TEST  = 2'b01,
    GRP_CLR   = 2'b10,
    GRP_SET   = 2'b11
  } grp_e;

  typedef enum logic [2:0] {
    SH_RLC = 3'd0,
    SH_RRC = 3'd1,
    SH_RLT = 3'd2,
    SH_RRT = 3'd3,
    SH_SLA = 3'd4,
    SH_SRA = 3'd5,
    SH_RSV = 3'd6,
    SH_SRL = 3'd7
  } sub_e;

  typedef struct packed {
    grp_e       grp;
    logic [2:0] fld;
    logic [2:0] dst;
  } dec_t;
endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bsr_decode.sv
module bsr_decode
  import bsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [OP_W-1:0] op,
  output dec_t            dec,
  output logic [DW-1:0]   mask
);
  always_comb begin
    dec.grp = grp_e'(op[7:6]);
    dec.fld = op[5:3];
    dec.dst = op[2:0];
  end

  // one-hot bit select from the middle field
  generate
    for (genvar i = 0; i < DW; i++) begin : g_mask
      assign mask[i] = (op[5:3] == 3'(i));
    end
  endgenerate
endmodule

// File: rtl/bsr_shift.sv
module bsr_shift
  import bsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opnd,
  input  sub_e          sub,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          rsv
);
  localparam int MSB = DW - 1;

  always_comb begin
    res  = opnd;
    cout = cin;
    rsv  = 1'b0;
    case (sub)
      SH_RLC: begin res = {opnd[MSB-1:0], opnd[MSB]}; cout = opnd[MSB]; end
      SH_RRC: begin res = {opnd[0], opnd[MSB:1]};     cout = opnd[0];   end
      SH_RLT: begin res = {opnd[MSB-1:0], cin};       cout = opnd[MSB]; end
      SH_RRT: begin res = {cin, opnd[MSB:1]};         cout = opnd[0];   end
      SH_SLA: begin res = {opnd[MSB-1:0], 1'b0};      cout = opnd[MSB]; end
      SH_SRA: begin res = {opnd[MSB], opnd[MSB:1]};   cout = opnd[0];   end
      SH_SRL: begin res = {1'b0, opnd[MSB:1]};        cout = opnd[0];   end
      SH_RSV: rsv = 1'b1;
      default: rsv = 1'b1;
    endcase
  end
endmodule

// File: rtl/bsr_bitop.sv
module bsr_bitop
  import bsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] opnd,
  input  logic [DW-1:0] mask,
  input  grp_e          grp,
  output logic [DW-1:0] res,
  output logic          hit
);
  assign hit = |(opnd & mask);

  always_comb begin
    case (grp)
      GRP_CLR: res = opnd & ~mask;
      GRP_SET: res = opnd | mask;
      default: res = opnd;
    endcase
  end
endmodule

// File: rtl/bsr_unit.sv
module bsr_unit
  import bsr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [OP_W-1:0]   in_op,
  input  logic [DW-1:0]     in_opnd,
  input  logic [FLAG_W-1:0] in_flags,
  output logic              out_vld,
  output logic [DW-1:0]     out_res,
  output logic              out_wr,
  output logic [2:0]        out_dst,
  output logic [FLAG_W-1:0] out_flags,
  output logic              out_illegal
);
  logic            rst_i_n;
  dec_t            dec;
  logic [DW-1:0]   mask;
  logic [DW-1:0]   sh_res;
  logic            sh_cout;
  logic            sh_rsv;
  logic [DW-1:0]   bit_res;
  logic            bit_hit;

  logic [DW-1:0]     nxt_res;
  logic              nxt_wr;
  logic [FLAG_W-1:0] nxt_flags;
  logic              nxt_ill;

  logic              vld_q;
  logic [DW-1:0]     res_q;
  logic              wr_q;
  logic [2:0]        dst_q;
  logic [FLAG_W-1:0] flags_q;
  logic              ill_q;

  bsr_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_i_n)
  );

  bsr_decode #(.DW(DW)) u_decode (
    .op  (in_op),
    .dec (dec),
    .mask(mask)
  );

  bsr_shift #(.DW(DW)) u_shift (
    .opnd(in_opnd),
    .sub (sub_e'(dec.fld)),
    .cin (in_flags[FLG_C]),
    .res (sh_res),
    .cout(sh_cout),
    .rsv (sh_rsv)
  );

  bsr_bitop #(.DW(DW)) u_bitop (
    .opnd(in_opnd),
    .mask(mask),
    .grp (dec.grp),
    .res (bit_res),
    .hit (bit_hit)
  );

  // next-state selection per group
  always_comb begin
    nxt_res   = in_opnd;
    nxt_wr    = 1'b0;
    nxt_flags = in_flags;
    nxt_ill   = 1'b0;
    case (dec.grp)
      GRP_TEST: nxt_flags[FLG_Z] = ~bit_hit;
      GRP_CLR, GRP_SET: begin
        nxt_res = bit_res;
        nxt_wr  = 1'b1;
      end
      default: begin
        if (sh_rsv) begin
          nxt_ill = 1'b1;
        end else begin
          nxt_res          = sh_res;
          nxt_wr           = 1'b1;
          nxt_flags[FLG_C] = sh_cout;
          nxt_flags[FLG_Z] = ~|sh_res;
          nxt_flags[FLG_S] = sh_res[DW-1];
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q   <= 1'b0;
      res_q   <= '0;
      wr_q    <= 1'b0;
      dst_q   <= '0;
      flags_q <= '0;
      ill_q   <= 1'b0;
    end else begin
      vld_q <= in_vld;
      if (in_vld) begin
        res_q   <= nxt_res;
        dst_q   <= dec.dst;
        flags_q <= nxt_flags;
      end
      wr_q  <= in_vld & nxt_wr;
      ill_q <= in_vld & nxt_ill;
    end
  end

  assign out_vld     = vld_q;
  assign out_res     = res_q;
  assign out_wr      = wr_q;
  assign out_dst     = dst_q;
  assign out_flags   = flags_q;
  assign out_illegal = ill_q;
endmodule

// File: rtl/bsr_unit_chk.sv
module bsr_unit_chk
  import bsr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [OP_W-1:0]   in_op,
  input logic [7:0]        in_opnd,
  input logic [FLAG_W-1:0] in_flags,
  input logic              out_vld,
  input logic [7:0]        out_res,
  input logic              out_wr,
  input logic [2:0]        out_dst,
  input logic [FLAG_W-1:0] out_flags,
  input logic              out_illegal
);
  p_vld_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  p_dst_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> out_dst == $past(in_op[2:0]));

  p_test_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(in_op[7:6]) == 2'b01) |->
      (!out_wr && out_flags[FLG_Z] == !$past(in_opnd[in_op[5:3]])));

  p_clr_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(in_op[7:6]) == 2'b10) |->
      (out_wr && out_flags == $past(in_flags) &&
       out_res == ($past(in_opnd) & ~(8'd1 << $past(in_op[5:3])))));

  p_set_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(in_op[7:6]) == 2'b11) |->
      (out_wr && out_flags == $past(in_flags) &&
       out_res == ($past(in_opnd) | (8'd1 << $past(in_op[5:3])))));

  p_shift_zs_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_vld && $past(in_op[7:6]) == 2'b00 && $past(in_op[5:3]) != 3'd6) |->
      (out_flags[FLG_Z] == (out_res == 8'd0) && out_flags[FLG_S] == out_res[7] &&
       out_flags[5:1] == $past(in_flags[5:1])));

  p_illegal_pass_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> (out_vld && !out_wr && out_res == $past(in_opnd) &&
                     out_flags == $past(in_flags)));

  p_no_wb_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_vld |-> (!out_wr && !out_illegal));
endmodule

bind bsr_unit bsr_unit_chk u_chk (.*);

// File: tb/bsr_unit_bench.sv
module bsr_unit_bench;
  logic       clk;
  logic       rst_n;
  logic       in_vld;
  logic [7:0] in_op;
  logic [7:0] in_opnd;
  logic [7:0] in_flags;
  logic       out_vld;
  logic [7:0] out_res;
  logic       out_wr;
  logic [2:0] out_dst;
  logic [7:0] out_flags;
  logic       out_illegal;

  int n_chk;
  int n_fail;
  bit gap_phase;
  bit run_mon;

  typedef struct {
    logic [7:0] r;
    logic       w;
    logic [2:0] d;
    logic [7:0] f;
    logic       ill;
    string      tag;
  } exp_t;

  exp_t sb_q[$];

  bsr_unit u_bsr_unit (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
    .in_opnd(in_opnd), .in_flags(in_flags), .out_vld(out_vld),
    .out_res(out_res), .out_wr(out_wr), .out_dst(out_dst),
    .out_flags(out_flags), .out_illegal(out_illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic ref_model(input logic [7:0] op, input logic [7:0] x,
                           input logic [7:0] fl, output exp_t e);
    int   n;
    logic c;
    n     = int'(op[5:3]);
    e.r   = x;
    e.w   = 1'b0;
    e.d   = op[2:0];
    e.f   = fl;
    e.ill = 1'b0;
    if (op >= 8'h40 && op <= 8'h7F) begin
      e.f[6] = (x[n] == 1'b0);
      e.tag  = "R3";
    end else if (op >= 8'h80 && op <= 8'hBF) begin
      e.r   = x & ~(8'h01 << n);
      e.w   = 1'b1;
      e.tag = "R4";
    end else if (op >= 8'hC0) begin
      e.r   = x | (8'h01 << n);
      e.w   = 1'b1;
      e.tag = "R5";
    end else begin
      c = fl[0];
      case (n)
        0: begin e.r = (x << 1) | (x >> 7);       c = x[7]; e.tag = "R6,R9"; end
        1: begin e.r = (x >> 1) | (x << 7);       c = x[0]; e.tag = "R6,R9"; end
        2: begin e.r = (x << 1) | {7'd0, fl[0]};  c = x[7]; e.tag = "R7,R9"; end
        3: begin e.r = (x >> 1) | {fl[0], 7'd0};  c = x[0]; e.tag = "R7,R9"; end
        4: begin e.r = x << 1;                    c = x[7]; e.tag = "R8,R9"; end
        5: begin e.r = 8'($signed(x) >>> 1);      c = x[0]; e.tag = "R8,R9"; end
        7: begin e.r = x >> 1;                    c = x[0]; e.tag = "R8,R9"; end
        default: begin e.ill = 1'b1; e.tag = "R10"; end
      endcase
      if (!e.ill) begin
        e.w    = 1'b1;
        e.f[0] = c;
        e.f[6] = (e.r == 8'd0);
        e.f[7] = e.r[7];
      end
    end
  endtask

  task automatic drive(input logic [7:0] op, input logic [7:0] x, input logic [7:0] fl);
    exp_t e;
    @(negedge clk);
    in_vld   = 1'b1;
    in_op    = op;
    in_opnd  = x;
    in_flags = fl;
    ref_model(op, x, fl, e);
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    in_vld   = 1'b0;
    in_op    = 8'h86;
    in_opnd  = 8'h3C;
    in_flags = 8'hFF;
  endtask

  // monitor: pops the scoreboard as results appear
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (run_mon) begin
        if (out_vld) begin
          if (sb_q.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R11 out_vld=1 with no operation pending, expected 0");
          end else begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (out_res !== e.r || out_wr !== e.w || out_dst !== e.d ||
                out_flags !== e.f || out_illegal !== e.ill) begin
              n_fail++;
              $display("FAIL %s R2 res=%h wr=%b dst=%0d flags=%h ill=%b, expected res=%h wr=%b dst=%0d flags=%h ill=%b",
                       e.tag, out_res, out_wr, out_dst, out_flags, out_illegal,
                       e.r, e.w, e.d, e.f, e.ill);
            end
          end
        end else begin
          if (sb_q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 out_vld=0 with %0d pending, expected 1", sb_q.size());
            void'(sb_q.pop_front());
          end else if (gap_phase) begin
            n_chk++;  // R11: idle cycle yields no result
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] pat_x [6];
    logic [7:0] pat_f [6];
    n_chk     = 0;
    n_fail    = 0;
    gap_phase = 1'b0;
    run_mon   = 1'b0;
    pat_x = '{8'h00, 8'hFF, 8'h80, 8'h01, 8'hA5, 8'h5A};
    pat_f = '{8'h00, 8'hFF, 8'h01, 8'h00, 8'hC1, 8'h3E};
    rst_n    = 1'b0;
    in_vld   = 1'b0;
    in_op    = 8'h00;
    in_opnd  = 8'h00;
    in_flags = 8'h00;

    // R1: outputs quiet while reset is held
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_vld !== 1'b0 || out_wr !== 1'b0 || out_illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 vld=%b wr=%b ill=%b, expected 0 0 0", out_vld, out_wr, out_illegal);
    end
    rst_n = 1'b1;
    repeat (4) idle();
    n_chk++;
    if (out_vld !== 1'b0 || out_wr !== 1'b0 || out_illegal !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 after release vld=%b wr=%b ill=%b, expected 0 0 0",
               out_vld, out_wr, out_illegal);
    end
    run_mon = 1'b1;

    // back-to-back sweep of every operation byte for each pattern
    for (int p = 0; p < 6; p++) begin
      for (int op = 0; op < 256; op++) begin
        drive(8'(op), pat_x[p], pat_f[p]);
      end
    end
    idle();
    idle();

    // sweep with idle cycles between operations (R11)
    gap_phase = 1'b1;
    for (int op = 0; op < 256; op++) begin
      drive(8'(op), 8'(op * 37 + 11), 8'(op ^ 8'h55));
      idle();
      if (op % 3 == 0) idle();
    end
    idle();
    idle();
    idle();
    gap_phase = 1'b0;

    n_chk++;
    if (sb_q.size() != 0) begin
      n_fail++;
      $display("FAIL R2 %0d results never appeared, expected 0", sb_q.size());
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule